// File: doc/BRIEF.md
# Double-Buffered Two-Channel DAC Register Front End

This block is the synchronous digital side of a two-channel digital-to-analog converter. A host drives a byte-wide parallel bus with an active-low select, an active-low write strobe, a channel address bit and a byte-select bit. Each channel builds its 12-bit code from two byte writes. The byte that carries the upper four code bits also carries two analog settings: reference buffering and output gain. Every strobe pin is brought onto the system clock through two flip-flops, and the end of a write is found from the synchronized write strobe.

Each channel has two layers of storage. The input layer takes the bus writes. The output layer holds the code and settings that the analog core uses. While the load strobe is low, a channel copies its input layer to its output layer, but only if the input layer was written since that channel last copied. A channel that saw no new write keeps its output, so the host can update both channels at once or update one alone. If the load strobe is tied low, each write reaches the output on its own. The active-low clear acts at once, without waiting for the clock, and sets every register to zero.

Bus handling is a three-state machine. BUS_IDLE waits for the synchronized write strobe to go low and moves to BUS_STROBE. BUS_STROBE records whether select was low at any time while the strobe was low. When the strobe rises, BUS_STROBE moves to BUS_COMMIT if select was seen low, and back to BUS_IDLE if it was not. BUS_COMMIT issues a one-cycle write to the addressed register. From BUS_COMMIT the machine moves to BUS_STROBE if the strobe is already low again, and to BUS_IDLE otherwise. While clear is asserted, and for two cycles after it is released, the machine is held in BUS_IDLE.

Top module: `dacif_dual_front`

## Requirements
- R1: While clr_n is low, every code output is 0 and every ref_buf and gain_x2 output is 0, without waiting for a clock edge. The same holds after power-up clear.
- R2: A write is accepted only if cs_n was low at some time while wr_n was low. A write strobe with cs_n held high changes no register.
- R3: The data is taken on the rising edge of wr_n. ch_sel = 0 addresses channel A and ch_sel = 1 addresses channel B. byte_hi = 0 loads code bits 7..0 from data[7:0]. byte_hi = 1 loads code bits 11..8 from data[3:0].
- R4: On a write with byte_hi = 1, data[4] sets the channel's ref_buf bit and data[5] sets its gain_x2 bit. data[7:6] are ignored.
- R5: While ldac_n is high, the code, ref_buf and gain_x2 outputs do not change.
- R6: While ldac_n is low, a channel copies its input registers to its outputs only if it was written since its last copy. A channel that was not written keeps its outputs.
- R7: With ldac_n held low, each accepted write appears at the outputs within 8 clock cycles of the wr_n rising edge.
- R8: A write of only the low byte, followed by a load, gives an output code made of the new low byte and the high byte, ref_buf and gain_x2 that were held before.
- R9: Clear zeroes the input registers and removes any pending copy. A load after clear is released leaves the outputs at zero, even if a write was pending or a write was attempted while clr_n was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| cs_n | input | 1 | Bus select, active low |
| wr_n | input | 1 | Write strobe, active low; data taken on its rising edge |
| ldac_n | input | 1 | Load strobe, active low, level sensitive |
| ch_sel | input | 1 | Channel address: 0 = A, 1 = B |
| byte_hi | input | 1 | Byte select: 0 = low code byte, 1 = upper code bits and settings |
| data | input | 8 | Bus data |
| code_a | output | 12 | Channel A output code |
| ref_buf_a | output | 1 | Channel A reference buffer enable |
| gain_x2_a | output | 1 | Channel A double-gain select |
| code_b | output | 12 | Channel B output code |
| ref_buf_b | output | 1 | Channel B reference buffer enable |
| gain_x2_b | output | 1 | Channel B double-gain select |

## Verification
The hardest case to reach from the ports is a load strobe that finds one channel written and the other untouched. Only the written channel may change, and nothing on the pins shows the per-channel pending state. The stimulus reaches this case with single-channel writes between load pulses, so each output change can only come from the channel that was written. The clear case is reached the same way: a write is left pending, then clear is pulsed with the load strobe held low, and finally a load is issued. This shows that clear removed the pending copy.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int DACIF_CODE_W = 12;
    localparam int DACIF_BYTE_W = 8;
    localparam int DACIF_HI_W   = DACIF_CODE_W - DACIF_BYTE_W;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_STROBE = 2'd1,
        BUS_COMMIT = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic [DACIF_CODE_W-1:0] code;
        logic                    ref_buf;
        logic                    gain_x2;
    } dac_word_t;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dacif_bus_fsm.sv
module dacif_bus_fsm
    import dacif_pkg::*;
#(
    parameter int BYTE_W = DACIF_BYTE_W,
    parameter int NCH    = 2
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              run,
    input  logic              wr_s,
    input  logic              cs_s,
    input  logic              ch_s,
    input  logic              hi_s,
    input  logic [BYTE_W-1:0] data_s,
    output logic [NCH-1:0]    ch_we,
    output logic              we_hi,
    output logic [BYTE_W-1:0] we_data
);

    bus_state_e        state_q, state_d;
    logic              seen_cs_q;
    logic              f_ch_q;
    logic              f_hi_q;
    logic [BYTE_W-1:0] f_data_q;

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= BUS_IDLE;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (run && !wr_s) state_d = BUS_STROBE;
            BUS_STROBE: if (wr_s) state_d = (seen_cs_q || !cs_s) ? BUS_COMMIT : BUS_IDLE;
            BUS_COMMIT: state_d = (run && !wr_s) ? BUS_STROBE : BUS_IDLE;
            default:    state_d = BUS_IDLE;
        endcase
        if (!run) state_d = BUS_IDLE;
    end

    // select tracking and field capture at the strobe's rising edge
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            seen_cs_q <= 1'b0;
            f_ch_q    <= 1'b0;
            f_hi_q    <= 1'b0;
            f_data_q  <= '0;
        end else begin
            if (state_q == BUS_STROBE) begin
                seen_cs_q <= seen_cs_q || !cs_s;
            end else if (state_d == BUS_STROBE) begin
                seen_cs_q <= !cs_s;
            end
            if (state_q == BUS_STROBE && wr_s) begin
                f_ch_q   <= ch_s;
                f_hi_q   <= hi_s;
                f_data_q <= data_s;
            end
        end
    end

    // outputs
    always_comb begin
        ch_we   = '0;
        we_hi   = f_hi_q;
        we_data = f_data_q;
        if (state_q == BUS_COMMIT) ch_we[f_ch_q] = 1'b1;
    end

endmodule

// File: rtl/dacif_chan.sv
module dacif_chan
    import dacif_pkg::*;
#(
    parameter int CODE_W = DACIF_CODE_W,
    parameter int BYTE_W = DACIF_BYTE_W
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              we,
    input  logic              we_hi,
    input  logic [BYTE_W-1:0] we_data,
    input  logic              ldac_s,
    output dac_word_t         dac_word,
    output logic              pending
);

    localparam int HI_W   = CODE_W - BYTE_W;
    localparam int RB_BIT = HI_W;
    localparam int GX_BIT = HI_W + 1;

    logic [BYTE_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic              rb_q;
    logic              gx_q;
    logic              pend_q;
    dac_word_t         dac_q;
    logic              load;

    assign load = !ldac_s && pend_q;

    // input layer
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            rb_q <= 1'b0;
            gx_q <= 1'b0;
        end else if (we) begin
            if (we_hi) begin
                hi_q <= we_data[HI_W-1:0];
                rb_q <= we_data[RB_BIT];
                gx_q <= we_data[GX_BIT];
            end else begin
                lo_q <= we_data;
            end
        end
    end

    // pending copy flag: a write wins over a simultaneous load
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)   pend_q <= 1'b0;
        else if (we)   pend_q <= 1'b1;
        else if (load) pend_q <= 1'b0;
    end

    // output layer
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            dac_q <= '0;
        end else if (load) begin
            dac_q.code    <= {hi_q, lo_q};
            dac_q.ref_buf <= rb_q;
            dac_q.gain_x2 <= gx_q;
        end
    end

    assign dac_word = dac_q;
    assign pending  = pend_q;

endmodule

// File: rtl/dacif_dual_front.sv
module dacif_dual_front
    import dacif_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic                    clk,
    input  logic                    clr_n,
    input  logic                    cs_n,
    input  logic                    wr_n,
    input  logic                    ldac_n,
    input  logic                    ch_sel,
    input  logic                    byte_hi,
    input  logic [DACIF_BYTE_W-1:0] data,
    output logic [DACIF_CODE_W-1:0] code_a,
    output logic                    ref_buf_a,
    output logic                    gain_x2_a,
    output logic [DACIF_CODE_W-1:0] code_b,
    output logic                    ref_buf_b,
    output logic                    gain_x2_b
);

    localparam int NCH   = 2;
    localparam int BUS_W = DACIF_BYTE_W + 2;

    logic [SYNC_N-1:0]       rel_q;
    logic                    run;
    logic [2:0]              strb_s;
    logic                    wr_s, cs_s, ldac_s;
    logic [BUS_W-1:0]        bus_s;
    logic [NCH-1:0]          ch_we;
    logic                    we_hi;
    logic [DACIF_BYTE_W-1:0] we_data;
    logic [NCH-1:0]          pend;
    dac_word_t               dac_w [NCH];

    // clear release synchronizer; assertion stays asynchronous
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) rel_q <= '0;
        else        rel_q <= {rel_q[SYNC_N-2:0], 1'b1};
    end
    assign run = rel_q[SYNC_N-1];

    dacif_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b111)) u_sync_strb (
        .clk    (clk),
        .arst_n (clr_n),
        .d      ({wr_n, cs_n, ldac_n}),
        .q      (strb_s)
    );
    assign {wr_s, cs_s, ldac_s} = strb_s;

    // bus fields delayed by the same depth so they line up with the strobe
    dacif_sync #(.W(BUS_W), .STAGES(SYNC_N), .RST_VAL('0)) u_sync_bus (
        .clk    (clk),
        .arst_n (clr_n),
        .d      ({ch_sel, byte_hi, data}),
        .q      (bus_s)
    );

    dacif_bus_fsm #(.BYTE_W(DACIF_BYTE_W), .NCH(NCH)) u_fsm (
        .clk     (clk),
        .arst_n  (clr_n),
        .run     (run),
        .wr_s    (wr_s),
        .cs_s    (cs_s),
        .ch_s    (bus_s[BUS_W-1]),
        .hi_s    (bus_s[BUS_W-2]),
        .data_s  (bus_s[DACIF_BYTE_W-1:0]),
        .ch_we   (ch_we),
        .we_hi   (we_hi),
        .we_data (we_data)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dacif_chan #(.CODE_W(DACIF_CODE_W), .BYTE_W(DACIF_BYTE_W)) u_ch (
            .clk      (clk),
            .arst_n   (clr_n),
            .we       (ch_we[i]),
            .we_hi    (we_hi),
            .we_data  (we_data),
            .ldac_s   (ldac_s),
            .dac_word (dac_w[i]),
            .pending  (pend[i])
        );
    end

    assign code_a    = dac_w[0].code;
    assign ref_buf_a = dac_w[0].ref_buf;
    assign gain_x2_a = dac_w[0].gain_x2;
    assign code_b    = dac_w[1].code;
    assign ref_buf_b = dac_w[1].ref_buf;
    assign gain_x2_b = dac_w[1].gain_x2;

endmodule

// File: rtl/dacif_dual_front_chk.sv
module dacif_dual_front_chk (
    input logic        clk,
    input logic        clr_n,
    input logic        ldac_s,
    input logic [1:0]  ch_we,
    input logic [1:0]  pend,
    input logic [11:0] code_a,
    input logic        ref_buf_a,
    input logic        gain_x2_a,
    input logic [11:0] code_b,
    input logic        ref_buf_b,
    input logic        gain_x2_b
);

    logic [13:0] out_a, out_b;
    assign out_a = {code_a, ref_buf_a, gain_x2_a};
    assign out_b = {code_b, ref_buf_b, gain_x2_b};

    always @(posedge clk) begin
        if (!clr_n) begin
            a_r1_clear_zero: assert (out_a == '0 && out_b == '0);
        end
        a_r2_single_write: assert ($onehot0(ch_we));
    end

    a_r5_hold_a: assert property (@(posedge clk) disable iff (!clr_n)
        ldac_s |=> $stable(out_a));
    a_r5_hold_b: assert property (@(posedge clk) disable iff (!clr_n)
        ldac_s |=> $stable(out_b));
    a_r6_no_reload_a: assert property (@(posedge clk) disable iff (!clr_n)
        !pend[0] |=> $stable(out_a));
    a_r6_no_reload_b: assert property (@(posedge clk) disable iff (!clr_n)
        !pend[1] |=> $stable(out_b));
    a_r6_pend_drop_a: assert property (@(posedge clk) disable iff (!clr_n)
        (pend[0] && !ldac_s && !ch_we[0]) |=> !pend[0]);
    a_r7_pend_set_b: assert property (@(posedge clk) disable iff (!clr_n)
        ch_we[1] |=> pend[1]);

endmodule

bind dacif_dual_front dacif_dual_front_chk u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .ldac_s    (ldac_s),
    .ch_we     (ch_we),
    .pend      (pend),
    .code_a    (code_a),
    .ref_buf_a (ref_buf_a),
    .gain_x2_a (gain_x2_a),
    .code_b    (code_b),
    .ref_buf_b (ref_buf_b),
    .gain_x2_b (gain_x2_b)
);

// File: tb/dacif_dual_front_tb.sv
module dacif_dual_front_tb;

    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        ldac_n = 1'b1;
    logic        ch_sel = 1'b0;
    logic        byte_hi = 1'b0;
    logic [7:0]  data = '0;
    logic [11:0] code_a, code_b;
    logic        ref_buf_a, gain_x2_a, ref_buf_b, gain_x2_b;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dacif_dual_front u_dut (
        .clk       (clk),
        .clr_n     (clr_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .ldac_n    (ldac_n),
        .ch_sel    (ch_sel),
        .byte_hi   (byte_hi),
        .data      (data),
        .code_a    (code_a),
        .ref_buf_a (ref_buf_a),
        .gain_x2_a (gain_x2_a),
        .code_b    (code_b),
        .ref_buf_b (ref_buf_b),
        .gain_x2_b (gain_x2_b)
    );

    function automatic logic [13:0] pk(input logic [11:0] c, input logic rb, input logic gx);
        return {c, rb, gx};
    endfunction

    task automatic chk(input string req, input logic [13:0] exp_a, input logic [13:0] exp_b);
        logic [13:0] act_a, act_b;
        act_a = {code_a, ref_buf_a, gain_x2_a};
        act_b = {code_b, ref_buf_b, gain_x2_b};
        total++;
        if (act_a !== exp_a || act_b !== exp_b) begin
            bad++;
            $display("FAIL %s: A actual=%h expected=%h, B actual=%h expected=%h",
                     req, act_a, exp_a, act_b, exp_b);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic ch, input logic hi, input logic [7:0] d, input logic sel);
        @(negedge clk);
        ch_sel = ch; byte_hi = hi; data = d; cs_n = !sel;
        idle(1);
        wr_n = 1'b0;
        idle(3);
        wr_n = 1'b1;
        idle(3);
        cs_n = 1'b1;
        idle(6);
    endtask

    task automatic pulse_load();
        @(negedge clk);
        ldac_n = 1'b0;
        idle(4);
        ldac_n = 1'b1;
        idle(4);
    endtask

    task automatic t_reset();
        idle(3);
        chk("R1 during clear", '0, '0);
        clr_n = 1'b1;
        idle(4);
        chk("R1 after clear release", '0, '0);
    endtask

    task automatic t_double_buffer();
        bus_write(1'b0, 1'b0, 8'h5A, 1'b1);
        bus_write(1'b0, 1'b1, 8'hF3, 1'b1);
        chk("R5 outputs held with load high", '0, '0);
        pulse_load();
        chk("R3 R4 R6 word assembled on load, B untouched", pk(12'h35A, 1, 1), '0);
    endtask

    task automatic t_select();
        bus_write(1'b1, 1'b0, 8'h77, 1'b0);
        pulse_load();
        chk("R2 write with select high ignored", pk(12'h35A, 1, 1), '0);
        bus_write(1'b1, 1'b0, 8'h11, 1'b1);
        pulse_load();
        chk("R2 R6 only B reloads", pk(12'h35A, 1, 1), pk(12'h011, 0, 0));
    endtask

    task automatic t_partial();
        bus_write(1'b0, 1'b0, 8'h0C, 1'b1);
        pulse_load();
        chk("R8 low byte only keeps high part", pk(12'h30C, 1, 1), pk(12'h011, 0, 0));
    endtask

    task automatic t_settings();
        bus_write(1'b1, 1'b1, 8'h2A, 1'b1);
        pulse_load();
        chk("R4 gain from bit5, buffer off", pk(12'h30C, 1, 1), pk(12'hA11, 0, 1));
        bus_write(1'b1, 1'b1, 8'hC0, 1'b1);
        pulse_load();
        chk("R4 bits 7:6 ignored", pk(12'h30C, 1, 1), pk(12'h011, 0, 0));
    endtask

    task automatic t_tied_load();
        @(negedge clk);
        ldac_n = 1'b0;
        bus_write(1'b0, 1'b0, 8'hFF, 1'b1);
        chk("R7 follows write with load low", pk(12'h3FF, 1, 1), pk(12'h011, 0, 0));
        bus_write(1'b0, 1'b1, 8'h00, 1'b1);
        chk("R7 R6 second write follows, B kept", pk(12'h0FF, 0, 0), pk(12'h011, 0, 0));
        ldac_n = 1'b1;
        idle(4);
    endtask

    task automatic t_clear();
        bus_write(1'b0, 1'b0, 8'h55, 1'b1);
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        chk("R1 clear acts without a clock edge", '0, '0);
        ldac_n = 1'b0;
        bus_write(1'b1, 1'b0, 8'h99, 1'b1);
        chk("R9 clear overrides write and load", '0, '0);
        clr_n = 1'b1;
        idle(8);
        chk("R9 no stale pending after clear", '0, '0);
        ldac_n = 1'b1;
        idle(2);
        pulse_load();
        chk("R9 load after clear keeps zero", '0, '0);
    endtask

    initial begin
        t_reset();
        t_double_buffer();
        t_select();
        t_partial();
        t_settings();
        t_tied_load();
        t_clear();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule